// File: doc/BRIEF.md
# Super I/O Configuration Unlock Controller

This block is the configuration-space front end of a peripheral combo chip. It snoops byte writes on an I/O address bus and recognises two ports: an index port and the data port directly above it. Configuration space stays sealed until software writes a two-byte key to the index port. The space is sealed again by a single exit byte. While the space is open, an index written to the index port selects a register, and the data port reads or writes that register.

Two registers are global: the current logical-device selector and a power control byte. All other registers are banked per logical device and are chosen by the selector. Each device has an enable bit, a 16-bit I/O base written as two bytes, an interrupt select, a second interrupt select for the mouse port, and a DMA channel select. Banks exist only for the devices marked in a parameter mask. By default these are devices 0 to 7 and 11. Every device's enable bit and I/O base are driven on output ports, so the peripheral decoders can use them.

Reads have no side effects, so the bus carries no read strobe. `io_rdata` always reflects whichever port `io_addr` currently selects.

Top module: `sio_cfg_unlock`

## Requirements
- R1: Only writes to address 0x03F0 (index port) and 0x03F1 (data port) are decoded. Writes to any other address change neither the key state nor any register.
- R2: An index-port write of 0x51 followed by an index-port write of 0x23 opens configuration space. `cfg_open` goes high in the cycle after the 0x23 write.
- R3: After 0x51, any index-port write other than 0x23 or 0x51 returns the key logic to the sealed state. A repeated 0x51 keeps the sequence primed, so a following 0x23 still opens the space.
- R4: While open, an index-port write of 0xBB seals the space. `cfg_open` is low from the next cycle.
- R5: While sealed, both ports read 0xFF and data-port writes are discarded.
- R6: While open, any other index-port write stores the index, and the index port reads it back.
- R7: Index 0x07 is the logical-device selector and index 0x22 is the power control byte. Both are global and can be read back.
- R8: Banked registers for the selected device sit at these indexes: 0x30 enable (bit 0, read as 0000000e), 0x60 base high byte, 0x61 base low byte, 0x70 IRQ select, 0x72 mouse IRQ select, 0x74 DMA select. For device k, `dev_active[k]` is the enable bit and `dev_iobase[16k+15:16k]` is {high, low}.
- R9: An index with no register behind it, or a selector naming a device with no bank (8, 9, 10 or 12 and above), reads 0x00. Writes to it change nothing.
- R10: After reset the space is sealed, and every register and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the addressed port (combinational) |
| cfg_open | output | 1 | Configuration space is open |
| dev_active | output | 12 | Enable bit of each logical device |
| dev_iobase | output | 192 | I/O base of each logical device, 16 bits per device |

## Verification
The assertions check the following on every cycle:
- The space opens only straight after the second key byte, and only from the primed state.
- The primed state is entered only on the first key byte.
- The exit byte seals the space.
- The index and selector load the written byte.
- A bank never changes without its write enable.
- No device output moves while the space is sealed or when the selector names a device with no bank.

Only the directed scenarios can show the rest:
- Sequences that break or restart the key.
- Banking, where values persist across selector changes.
- The 0x00 and 0xFF read values.
- Writes discarded while sealed, which become visible only after the space is reopened.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    KEY_SEALED = 2'd0,
    KEY_PRIMED = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h51;
  localparam logic [7:0] KEY_SECOND = 8'h23;
  localparam logic [7:0] KEY_EXIT   = 8'hBB;

  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] IDX_POWER   = 8'h22;
  localparam logic [7:0] IDX_ENABLE  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_MSIRQ   = 8'h72;
  localparam logic [7:0] IDX_DMA     = 8'h74;

endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic       idx_load
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        KEY_SEALED: if (wdata == KEY_FIRST) st_d = KEY_PRIMED;
        KEY_PRIMED: begin
          if (wdata == KEY_SECOND)     st_d = KEY_OPEN;
          else if (wdata != KEY_FIRST) st_d = KEY_SEALED;
        end
        KEY_OPEN:   if (wdata == KEY_EXIT) st_d = KEY_SEALED;
        default:    st_d = KEY_SEALED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_SEALED;
    else        st_q <= st_d;
  end

  assign open     = (st_q == KEY_OPEN);
  assign idx_load = open && idx_wr && (wdata != KEY_EXIT);

  logic primed;
  assign primed = (st_q == KEY_PRIMED);

  // R2: the space opens only from the primed state, on the second key byte
  a_r2_open_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(primed && idx_wr && wdata == KEY_SECOND));

  // R3: the primed state is entered only on the first key byte
  a_r3_primed_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> $past(idx_wr && wdata == KEY_FIRST));

  // R4: the exit byte seals the space
  a_r4_exit_seals: assert property (@(posedge clk) disable iff (!rst_n)
    (open && idx_wr && wdata == KEY_EXIT) |=> !open);
endmodule

// File: rtl/sio_glb_regs.sv
module sio_glb_regs
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_load,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] index,
  output logic [7:0] devsel,
  output logic [7:0] power
);
  logic [7:0] index_d, devsel_d, power_d;

  always_comb begin
    index_d  = index;
    devsel_d = devsel;
    power_d  = power;
    if (idx_load) index_d = wdata;
    if (data_wr && index == IDX_DEVSEL) devsel_d = wdata;
    if (data_wr && index == IDX_POWER)  power_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index  <= '0;
      devsel <= '0;
      power  <= '0;
    end else begin
      index  <= index_d;
      devsel <= devsel_d;
      power  <= power_d;
    end
  end

  // R6: an index write loads the written byte
  a_r6_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> index == $past(wdata));

  // R7: a data write at the selector index loads the selector
  a_r7_devsel_load: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && index == IDX_DEVSEL) |=> devsel == $past(wdata));
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  index,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_data,
  output logic        active,
  output logic [15:0] iobase
);
  logic       en_q, en_d;
  logic [7:0] hi_q, hi_d, lo_q, lo_d;
  logic [7:0] irq_q, irq_d, msirq_q, msirq_d, dma_q, dma_d;

  always_comb begin
    en_d    = en_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    irq_d   = irq_q;
    msirq_d = msirq_q;
    dma_d   = dma_q;
    if (wr_en) begin
      case (index)
        IDX_ENABLE:  en_d    = wdata[0];
        IDX_BASE_HI: hi_d    = wdata;
        IDX_BASE_LO: lo_d    = wdata;
        IDX_IRQ:     irq_d   = wdata;
        IDX_MSIRQ:   msirq_d = wdata;
        IDX_DMA:     dma_d   = wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      irq_q   <= '0;
      msirq_q <= '0;
      dma_q   <= '0;
    end else begin
      en_q    <= en_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      irq_q   <= irq_d;
      msirq_q <= msirq_d;
      dma_q   <= dma_d;
    end
  end

  always_comb begin
    case (index)
      IDX_ENABLE:  rd_data = {7'b0, en_q};
      IDX_BASE_HI: rd_data = hi_q;
      IDX_BASE_LO: rd_data = lo_q;
      IDX_IRQ:     rd_data = irq_q;
      IDX_MSIRQ:   rd_data = msirq_q;
      IDX_DMA:     rd_data = dma_q;
      default:     rd_data = 8'h00;
    endcase
  end

  assign active = en_q;
  assign iobase = {hi_q, lo_q};

  // R8: a bank holds its contents unless it is written
  a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({en_q, hi_q, lo_q, irq_q, msirq_q, dma_q}));
endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [15:0]     INDEX_PORT = 16'h03F0,
  parameter int              NUM_LDN    = 12,
  parameter logic [11:0]     LDN_MASK   = 12'h8FF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_open,
  output logic [NUM_LDN-1:0]    dev_active,
  output logic [NUM_LDN*16-1:0] dev_iobase
);
  localparam int                LDN_W     = $clog2(NUM_LDN);
  localparam logic [ADDR_W-1:0] IDX_ADDR  = ADDR_W'(INDEX_PORT);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(INDEX_PORT) + ADDR_W'(1);

  logic       rst_i_n;
  logic       at_idx, at_data, idx_wr, data_wr, idx_load;
  logic [7:0] index_q, devsel_q, power_q;
  logic [7:0] bank_rd [NUM_LDN];
  logic [7:0] bank_sel_rd, cfg_rd;
  logic       devsel_hit;

  sio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign at_idx  = (io_addr == IDX_ADDR);
  assign at_data = (io_addr == DATA_ADDR);
  assign idx_wr  = io_wr && at_idx;
  assign data_wr = io_wr && at_data && cfg_open;

  sio_key_fsm u_key (
    .clk(clk), .rst_n(rst_i_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .open(cfg_open), .idx_load(idx_load)
  );

  sio_glb_regs u_glb (
    .clk(clk), .rst_n(rst_i_n), .idx_load(idx_load), .data_wr(data_wr),
    .wdata(io_wdata), .index(index_q), .devsel(devsel_q), .power(power_q)
  );

  for (genvar k = 0; k < NUM_LDN; k++) begin : g_ldn
    if (LDN_MASK[k]) begin : g_bank
      sio_dev_bank u_bank (
        .clk(clk), .rst_n(rst_i_n),
        .wr_en(data_wr && devsel_q == 8'(k)),
        .index(index_q), .wdata(io_wdata), .rd_data(bank_rd[k]),
        .active(dev_active[k]), .iobase(dev_iobase[16*k +: 16])
      );
    end else begin : g_none
      assign bank_rd[k]             = 8'h00;
      assign dev_active[k]          = 1'b0;
      assign dev_iobase[16*k +: 16] = 16'h0000;
    end
  end

  assign devsel_hit  = (devsel_q < 8'(NUM_LDN));
  assign bank_sel_rd = devsel_hit ? bank_rd[devsel_q[LDN_W-1:0]] : 8'h00;

  always_comb begin
    case (index_q)
      IDX_DEVSEL: cfg_rd = devsel_q;
      IDX_POWER:  cfg_rd = power_q;
      default:    cfg_rd = bank_sel_rd;
    endcase
  end

  always_comb begin
    if (!cfg_open)    io_rdata = 8'hFF;
    else if (at_idx)  io_rdata = index_q;
    else if (at_data) io_rdata = cfg_rd;
    else              io_rdata = 8'hFF;
  end

  // R5: nothing a device sees moves while the space is sealed
  a_r5_sealed_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_open |=> $stable(dev_active) && $stable(dev_iobase));

  // R9: a write under a selector with no bank moves no device output
  a_r9_no_bank_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!devsel_hit || !LDN_MASK[devsel_q[LDN_W-1:0]]) |=>
      $stable(dev_active) && $stable(dev_iobase));
endmodule

// File: tb/sio_cfg_unlock_tb.sv
module sio_cfg_unlock_tb;
  localparam logic [15:0] PI = 16'h03F0;
  localparam logic [15:0] PD = 16'h03F1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  io_addr;
  logic         io_wr;
  logic [7:0]   io_wdata;
  logic [7:0]   io_rdata;
  logic         cfg_open;
  logic [11:0]  dev_active;
  logic [191:0] dev_iobase;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sio_cfg_unlock u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .dev_iobase(dev_iobase)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(PI, idx); wr(PD, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    wr(PI, idx); rd(PD, d);
  endtask

  function automatic logic [15:0] base_of(input int k);
    return dev_iobase[16*k +: 16];
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    @(negedge clk);
    chk("R10 open after reset", cfg_open, 0);
    chk("R10 active after reset", dev_active, 0);
    chk("R10 base dev0 after reset", base_of(0), 0);
    chk("R10 base dev11 after reset", base_of(11), 0);
    rd(PD, d); chk("R5 sealed data read", d, 8'hFF);
  endtask

  task automatic t_sealed;
    logic [7:0] d;
    wr(PI, 8'h07); wr(PD, 8'h04);
    rd(PI, d); chk("R5 sealed index read", d, 8'hFF);
    chk("R5 sealed write leaves space sealed", cfg_open, 0);
  endtask

  task automatic t_key_seq;
    wr(PI, 8'h51); wr(PI, 8'h24);
    chk("R3 broken key stays sealed", cfg_open, 0);
    wr(PI, 8'h23);
    chk("R3 lone second byte stays sealed", cfg_open, 0);
    wr(PI, 8'h51); wr(PI, 8'h51); wr(PI, 8'h23);
    chk("R3 repeated first byte still opens", cfg_open, 1);
    wr(PI, 8'hBB);
    chk("R4 exit seals", cfg_open, 0);
    wr(16'h02F0, 8'h51); wr(PI, 8'h23);
    chk("R1 key at foreign address ignored", cfg_open, 0);
  endtask

  task automatic t_unlock;
    logic [7:0] d;
    wr(PI, 8'h51);
    chk("R2 one byte does not open", cfg_open, 0);
    wr(PI, 8'h23);
    chk("R2 key opens", cfg_open, 1);
    reg_rd(8'h07, d); chk("R5 sealed data write discarded", d, 8'h00);
  endtask

  task automatic t_globals;
    logic [7:0] d;
    wr(PI, 8'h22);
    rd(PI, d); chk("R6 index readback", d, 8'h22);
    wr(PD, 8'h5A);
    rd(PD, d); chk("R7 power readback", d, 8'h5A);
    reg_wr(8'h07, 8'h04);
    rd(PD, d); chk("R7 selector readback", d, 8'h04);
  endtask

  task automatic t_banks;
    logic [7:0] d;
    reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'hF8); reg_wr(8'h30, 8'hFF);
    chk("R8 dev4 base", base_of(4), 16'h02F8);
    chk("R8 dev4 enable", dev_active, 12'h010);
    reg_rd(8'h30, d); chk("R8 enable reads bit0 only", d, 8'h01);
    reg_wr(8'h70, 8'h03); reg_rd(8'h70, d); chk("R8 irq readback", d, 8'h03);
    reg_wr(8'h74, 8'h02); reg_rd(8'h74, d); chk("R8 dma readback", d, 8'h02);
    reg_wr(8'h72, 8'h0C); reg_rd(8'h72, d); chk("R8 mouse irq readback", d, 8'h0C);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h60, d); chk("R8 dev7 bank separate", d, 8'h00);
    reg_wr(8'h61, 8'h60);
    chk("R8 dev7 base", base_of(7), 16'h0060);
    reg_wr(8'h07, 8'h04);
    reg_rd(8'h61, d); chk("R8 dev4 kept across selector", d, 8'hF8);
    wr(PI, 8'h60); wr(16'h03F2, 8'h99);
    chk("R1 foreign address write ignored", base_of(4), 16'h02F8);
    reg_wr(8'h07, 8'h0B);
    reg_wr(8'h61, 8'hE8); reg_wr(8'h60, 8'h03);
    chk("R8 dev11 base", base_of(11), 16'h03E8);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h60, 8'h12);
    reg_rd(8'h60, d); chk("R9 no-bank device reads zero", d, 8'h00);
    chk("R9 no-bank device base", base_of(9), 16'h0000);
    reg_wr(8'h07, 8'h20);
    reg_wr(8'h30, 8'h01);
    reg_rd(8'h30, d); chk("R9 selector out of range reads zero", d, 8'h00);
    chk("R9 enables unchanged", dev_active, 12'h010);
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h40, 8'h77);
    reg_rd(8'h40, d); chk("R9 empty index reads zero", d, 8'h00);
  endtask

  task automatic t_exit;
    logic [7:0] d;
    reg_wr(8'h07, 8'h0B);
    wr(PI, 8'hBB);
    chk("R4 exit seals again", cfg_open, 0);
    rd(PD, d); chk("R5 sealed read after exit", d, 8'hFF);
    wr(PI, 8'h61); wr(PD, 8'h00);
    chk("R5 sealed write keeps base", base_of(11), 16'h03E8);
    wr(PI, 8'h51); wr(PI, 8'h23);
    reg_rd(8'h61, d); chk("R5 discarded write not stored", d, 8'hE8);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_sealed;
    t_key_seq;
    t_unlock;
    t_globals;
    t_banks;
    t_unimpl;
    t_exit;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule